// File: doc/BRIEF.md
# Dual-Channel Quarter-Wave Sine Generator

This block turns two independent phase words into two streams of signed sine samples. It keeps magnitudes for only the first quarter of a period, which is one fourth of the storage a full-period table would need. The other three quarters are rebuilt as follows. The top two phase bits pick the quadrant. In the second and fourth quadrants the low phase bits are inverted, so the table is read in mirror order. In the lower half cycle the magnitude is negated.

Both channels read the one shared table, each through its own read port. The read is registered on every clock with no enable, so the table maps onto on-chip dual-port block memory. Each channel delivers one new sample on every clock, which supports a sustained rate of 50 million samples per second per channel. A phase accumulator upstream feeds the phase inputs, and the samples go to a converter downstream.

The table is filled at elaboration time from a formula. Entry k holds round(A·sin(π(2k+1)/(4N))), where N = 2^IDX_W and A = 2^(WIDTH−1)−1. The half-step offset makes each mirrored quadrant exact.

Top module: `qsine_dual`

## Requirements
- R1: For a phase p whose top two bits are 00, the sample equals +T[p mod N], where T is the quarter table.
- R2: For top bits 01, the sample equals +T[N−1−(p mod N)], which is the table read with the low phase bits inverted.
- R3: For top bits 10, the sample equals −T[p mod N], so every sample of the lower half cycle is negative.
- R4: For top bits 11, the sample equals −T[N−1−(p mod N)].
- R5: A phase presented before clock edge k appears as a sample after edge k+2, a fixed latency of three clocks. A new sample is produced on every clock, and a phase held steady gives a steady sample.
- R6: The two channels are independent. Equal phases on both inputs give equal samples, whatever the other channel does.
- R7: While rst_n is low at a clock edge, both sample outputs read zero after that edge.
- R8: T[k] = round((2^(WIDTH−1)−1)·sin(π(2k+1)/(4N))). Samples are two's complement, WIDTH bits wide, and never take the most negative code.
- R9: Odd symmetry: the sample for the bitwise complement ~p is the negation of the sample for p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_phase | input | IDX_W+2 | Phase word of channel A; the top two bits are the quadrant |
| b_phase | input | IDX_W+2 | Phase word of channel B; the top two bits are the quadrant |
| a_sample | output | WIDTH | Signed sample of channel A |
| b_sample | output | WIDTH | Signed sample of channel B |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:
- Quadrant edges, such as phases N−1, N, 2N−1 and 2N. A fold that mirrors the wrong quadrant repeats or skips a peak, or puts a step in the wave there.
- The complement pairing, where channel B takes ~p while channel A takes p. This exposes a sign flag that is not delayed enough and so meets the wrong sample, since the two outputs then stop cancelling.
- Half-turn offsets between the channels, which catch a negation applied to the wrong half cycle.
- Held phases, which reveal an output that drifts without a phase change.
- The reset window, which shows outputs that are not cleared.

// File: rtl/qsine_dual.sv
module qsine_dual #(
  parameter int WIDTH = 12,
  parameter int IDX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W+1:0]        a_phase,
  input  logic [IDX_W+1:0]        b_phase,
  output logic signed [WIDTH-1:0] a_sample,
  output logic signed [WIDTH-1:0] b_sample
);
  localparam int  DEPTH = 1 << IDX_W;
  localparam real AMP   = real'((1 << (WIDTH - 1)) - 1);
  localparam real PI    = 3.14159265358979323846;

  function automatic logic [WIDTH-2:0] quarter_val(input int k);
    real s;
    s = AMP * $sin(PI * (2.0 * k + 1.0) / (4.0 * DEPTH));
    return (WIDTH-1)'($rtoi(s + 0.5));
  endfunction

  logic [WIDTH-2:0] rom [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom[k] = quarter_val(k);
  end

  logic [1:0][IDX_W+1:0] ph;
  assign ph = {b_phase, a_phase};

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [IDX_W-1:0] lo;
    logic [IDX_W-1:0] addr_q;
    logic             neg1_q, neg2_q;
    logic [WIDTH-2:0] mag_q;
    logic [WIDTH-1:0] ext;
    logic [WIDTH-1:0] out_q;

    assign lo  = ph[c][IDX_W-1:0];
    assign ext = {1'b0, mag_q};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q <= '0;
        neg1_q <= 1'b0;
        neg2_q <= 1'b0;
        out_q  <= '0;
      end else begin
        addr_q <= ph[c][IDX_W] ? ~lo : lo;
        neg1_q <= ph[c][IDX_W+1];
        neg2_q <= neg1_q;
        out_q  <= neg2_q ? -ext : ext;
      end
    end

    always_ff @(posedge clk) mag_q <= rom[addr_q];
  end

  assign a_sample = g_ch[0].out_q;
  assign b_sample = g_ch[1].out_q;
endmodule

// File: rtl/qsine_dual_chk.sv
module qsine_dual_chk #(
  parameter int WIDTH = 12,
  parameter int IDX_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [IDX_W+1:0]        a_phase,
  input logic [IDX_W+1:0]        b_phase,
  input logic signed [WIDTH-1:0] a_sample,
  input logic signed [WIDTH-1:0] b_sample
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [2:0] fill;
  always_ff @(posedge clk) begin
    if (!rst_n) fill <= '0;
    else if (fill != 3'd4) fill <= fill + 3'd1;
  end

  logic ready3, ready4;
  assign ready3 = (fill >= 3'd3);
  assign ready4 = (fill == 3'd4);

  p_sign_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready3 |-> a_sample[WIDTH-1] == $past(a_phase[IDX_W+1], 3));
  p_sign_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready3 |-> b_sample[WIDTH-1] == $past(b_phase[IDX_W+1], 3));
  p_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready3 && $past(b_phase, 3) == ~$past(a_phase, 3)) |-> (a_sample + b_sample) == '0);
  p_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready3 && $past(b_phase, 3) == $past(a_phase, 3)) |-> a_sample == b_sample);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready4 && $past(a_phase, 3) == $past(a_phase, 4)) |-> $stable(a_sample));
  p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready3 |-> (a_sample != MOST_NEG && b_sample != MOST_NEG));
endmodule

bind qsine_dual qsine_dual_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_qsine_dual.sv
`timescale 1ns/1ps
module tb_qsine_dual;
  localparam int WIDTH = 12;
  localparam int IDX_W = 8;
  localparam int N     = 1 << IDX_W;
  localparam int PH    = IDX_W + 2;
  localparam int MASK  = (1 << PH) - 1;
  localparam real PI   = 3.14159265358979323846;
  localparam real AMP  = real'((1 << (WIDTH - 1)) - 1);

  logic clk = 0;
  logic rst_n = 0;
  logic [PH-1:0] a_phase = '0, b_phase = '0;
  logic signed [WIDTH-1:0] a_sample, b_sample;

  int checks = 0;
  int fails  = 0;
  int qa[$];
  int qb[$];

  always #4 clk = ~clk;

  qsine_dual #(.WIDTH(WIDTH), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .a_phase(a_phase), .b_phase(b_phase),
    .a_sample(a_sample), .b_sample(b_sample));

  // Reference from the angle itself: sin(2*pi*(p+0.5)/(4N)), rounded in magnitude (R8)
  function automatic int ref_val(int p);
    real s;
    int  m;
    s = $sin(2.0 * PI * (p + 0.5) / (4.0 * N));
    m = $rtoi(AMP * (s < 0.0 ? -s : s) + 0.5);
    return (s < 0.0) ? -m : m;
  endfunction

  function automatic string quad_tag(int p);
    case ((p >> IDX_W) & 3)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check_one(string ch, int p, int got);
    int exp_v;
    exp_v = ref_val(p);
    checks++;
    if (got != exp_v) begin
      fails++;
      $display("FAIL %s ch%s phase=%0d actual=%0d expected=%0d", quad_tag(p), ch, p, got, exp_v);
    end
  endtask

  // Three-clock latency (R5), channels checked separately (R6), values from formula (R8)
  task automatic step(int a, int b);
    if (qa.size() == 3) begin
      check_one("A", qa.pop_front(), int'(a_sample));
      check_one("B", qb.pop_front(), int'(b_sample));
    end
    a_phase = PH'(a & MASK);
    b_phase = PH'(b & MASK);
    qa.push_back(a & MASK);
    qb.push_back(b & MASK);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (a_sample != 0 || b_sample != 0) begin
      fails++;
      $display("FAIL R7 reset actual=%0d/%0d expected=0/0", a_sample, b_sample);
    end
    rst_n = 1;
    // complement pairing, full sweep (R9)
    for (int i = 0; i < 4 * N; i++) step(i, ~i);
    // half-turn offset between channels
    for (int i = 0; i < 4 * N; i++) step(i * 37 + 5, (i * 37 + 5) ^ (1 << (PH - 1)));
    // identical phases (R6)
    for (int i = 0; i < N; i++) step(i * 101, i * 101);
    // quadrant edges held steady (R5)
    for (int i = 0; i < 8; i++) step(N - 1, 2 * N);
    for (int i = 0; i < 8; i++) step(N, 2 * N - 1);
    for (int i = 0; i < 3; i++) step(0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule